// File: doc/BRIEF.md
# Integer ALU Execute Unit

This block decodes and executes one 32-bit three-operand instruction per accepted cycle against its own 32-entry, 32-bit register file. Source operands are read combinationally, the result is formed combinationally, and the destination register is written on the rising clock edge. It covers register-register add, subtract and signed set-less-than, plus the immediate forms add, set-less-than, AND, OR and load-upper.

Instructions arrive as a stream: `instr_valid` offers a word and `instr_ready` accepts it. The unit holds `instr_ready` low while reset is asserted and raises it on the first clock edge after reset is released. From then on it never applies back-pressure, so a word is consumed on every edge where `instr_valid` is high. An unrecognised word raises `illegal` in the same cycle and changes no register. A combinational debug read port shows any register's current contents.

Top module: `ixu_core`

## Requirements
- R1: Reset clears every register to zero and holds `instr_ready` low. `instr_ready` is high from the first edge after reset is released.
- R2: Register-format words decode as follows: opcode in bits 31:26, first source in 25:21, second source in 20:16, destination in 15:11 and function in 5:0. Opcode 0 with function 32 writes first source plus second source, modulo 2^32.
- R3: Opcode 0 with function 34 writes first source minus second source, modulo 2^32.
- R4: Opcode 0 with function 42 writes 1 when the first source is less than the second as a signed two's-complement number, and 0 otherwise.
- R5: Immediate-format words carry the source in bits 25:21, the target in 20:16 and a constant in 15:0. They write the target, never the register named by bits 15:11. Opcode 8 adds the sign-extended constant.
- R6: Opcode 10 writes 1 when the source is signed-less-than the sign-extended constant, and 0 otherwise.
- R7: Opcode 12 (AND) and opcode 13 (OR) combine the source with the zero-extended constant.
- R8: Opcode 15 writes the constant into bits 31:16 and zero into bits 15:0.
- R9: Register 0 always reads as zero, both as an operand and on the debug port. Writes to it are discarded.
- R10: A valid word with any other opcode, or with opcode 0 and any other function, drives `illegal` high in that cycle and writes nothing. `illegal` is low whenever `instr_valid` is low.
- R11: No register changes on an edge where `instr_valid` is low.
- R12: `dbg_data` shows the register selected by `dbg_addr`, including a write made on the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit accepts a word this cycle |
| instr_word | input | 32 | Instruction word |
| illegal | output | 1 | Offered word is not recognised |
| dbg_addr | input | 5 | Debug read register index |
| dbg_data | output | 32 | Debug read value |

## Verification
The hardest cases to reach from the ports involve operand values that separate signed from unsigned comparison, and sign extension from zero extension. Registers start at zero, so such values can only be built through the unit itself. The stimulus therefore first composes full 32-bit constants with load-upper followed by OR-immediate, creating one positive and one negative operand. It then feeds them to set-less-than and to immediates that have bit 15 set. It also sets ones in bits 15:11 of immediate words, so that a write to the wrong destination field would show up in register 31.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam int INSTR_W = 32;
  localparam int FLD_W   = 5;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LUI  = 6'd15;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_SLT, K_AND, K_OR, K_LUI
  } alu_kind_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT
  } bsrc_e;

  typedef struct packed {
    logic              legal;
    alu_kind_e         kind;
    bsrc_e             bsrc;
    logic [FLD_W-1:0]  ra;
    logic [FLD_W-1:0]  rb;
    logic [FLD_W-1:0]  dst;
    logic [IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
  import ixu_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output dec_t               dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = word[31:26];
  assign fn  = word[5:0];

  always_comb begin
    dec       = '0;
    dec.ra    = word[25:21];
    dec.rb    = word[20:16];
    dec.imm   = word[15:0];
    dec.dst   = word[20:16];
    dec.kind  = K_ADD;
    dec.bsrc  = SRC_SEXT;
    dec.legal = 1'b1;
    unique case (opc)
      OPC_REG: begin
        dec.dst  = word[15:11];
        dec.bsrc = SRC_REG;
        unique case (fn)
          FN_ADD:  dec.kind = K_ADD;
          FN_SUB:  dec.kind = K_SUB;
          FN_SLT:  dec.kind = K_SLT;
          default: dec.legal = 1'b0;
        endcase
      end
      OPC_ADDI: dec.kind = K_ADD;
      OPC_SLTI: dec.kind = K_SLT;
      OPC_ANDI: begin dec.kind = K_AND; dec.bsrc = SRC_ZEXT; end
      OPC_ORI:  begin dec.kind = K_OR;  dec.bsrc = SRC_ZEXT; end
      OPC_LUI:  begin dec.kind = K_LUI; dec.bsrc = SRC_ZEXT; end
      default:  dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
  import ixu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_kind_e         kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int UPPER_SH = DATA_W - IMM_W;

  always_comb begin
    unique case (kind)
      K_ADD:   y = a + b;
      K_SUB:   y = a - b;
      K_SLT:   y = ($signed(a) < $signed(b)) ? DATA_W'(1) : '0;
      K_AND:   y = a & b;
      K_OR:    y = a | b;
      K_LUI:   y = b << UPPER_SH;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ixu_regfile.sv
module ixu_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int RPORTS = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [RPORTS-1:0][AW-1:0]     raddr,
  output logic [RPORTS-1:0][DATA_W-1:0] rdata
);
  logic [DEPTH-1:0][DATA_W-1:0] regs;

  assign regs[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && waddr == AW'(i))
        regs[i] <= wdata;
    end
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rd
    assign rdata[p] = regs[raddr[p]];
  end
endmodule

// File: rtl/ixu_core.sv
module ixu_core
  import ixu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  output logic               illegal,
  input  logic [AW-1:0]      dbg_addr,
  output logic [DATA_W-1:0]  dbg_data
);
  localparam int RP = 3;

  dec_t                      dec;
  logic [RP-1:0][AW-1:0]     raddr;
  logic [RP-1:0][DATA_W-1:0] rdata;
  logic [DATA_W-1:0]         opb;
  logic [DATA_W-1:0]         result;
  logic                      ready_q;
  logic                      wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign instr_ready = ready_q;

  ixu_decode u_dec (.word(instr_word), .dec(dec));

  assign raddr[0] = AW'(dec.ra);
  assign raddr[1] = AW'(dec.rb);
  assign raddr[2] = dbg_addr;

  always_comb begin
    unique case (dec.bsrc)
      SRC_REG:  opb = rdata[1];
      SRC_SEXT: opb = {{(DATA_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
      default:  opb = {{(DATA_W-IMM_W){1'b0}}, dec.imm};
    endcase
  end

  ixu_alu #(.DATA_W(DATA_W)) u_alu (
    .kind(dec.kind), .a(rdata[0]), .b(opb), .y(result)
  );

  assign illegal = instr_valid && !dec.legal;
  assign wr_en   = instr_valid && ready_q && dec.legal;

  ixu_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RPORTS(RP)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(AW'(dec.dst)),
    .wdata(result), .raddr(raddr), .rdata(rdata)
  );

  assign dbg_data = rdata[2];
endmodule

// File: rtl/ixu_core_chk.sv
module ixu_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic        instr_ready,
  input logic [31:0] instr_word,
  input logic        illegal,
  input logic [4:0]  dbg_addr,
  input logic [31:0] dbg_data
);
  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == 5'd0) |-> (dbg_data == 32'd0));

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !illegal);

  p_illegal_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && illegal) |=>
      ((dbg_addr != $past(dbg_addr)) || (dbg_data == $past(dbg_data))));

  p_idle_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=>
      ((dbg_addr != $past(dbg_addr)) || (dbg_data == $past(dbg_data))));

  p_upper_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && instr_word[31:26] == 6'd15 &&
     instr_word[20:16] != 5'd0 && instr_word[20:16] == dbg_addr) |=>
      ((dbg_addr != $past(dbg_addr)) ||
       (dbg_data == {$past(instr_word[15:0]), 16'h0000})));

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> instr_ready);
endmodule

bind ixu_core ixu_core_chk u_chk (.*);

// File: tb/ixu_core_test.sv
module ixu_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic        illegal;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int total = 0;
  int bad   = 0;
  logic [31:0] mdl [32];

  typedef struct { logic [4:0] r; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  ixu_core uut (.*);

  function automatic logic [31:0] rt_w(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] it_w(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model built from the requirements
  task automatic model(input logic [31:0] w, output bit legal, output logic [4:0] d, output logic [31:0] v);
    logic [31:0] a, b, se, ze;
    a  = mdl[w[25:21]];
    b  = mdl[w[20:16]];
    se = {{16{w[15]}}, w[15:0]};
    ze = {16'h0, w[15:0]};
    legal = 1;
    d = w[20:16];
    v = 0;
    case (w[31:26])
      6'd0: begin
        d = w[15:11];
        case (w[5:0])
          6'd32: v = a + b;
          6'd34: v = a - b;
          6'd42: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: legal = 0;
        endcase
      end
      6'd8:  v = a + se;
      6'd10: v = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      6'd12: v = a & ze;
      6'd13: v = a | ze;
      6'd15: v = {w[15:0], 16'h0};
      default: legal = 0;
    endcase
  endtask

  // driver: offer one word, update model, queue expectations
  task automatic drive(input logic [31:0] w, input bit vld, input string tag);
    bit legal; logic [4:0] d; logic [31:0] v;
    model(w, legal, d, v);
    @(negedge clk);
    instr_word  = w;
    instr_valid = vld;
    #1;
    chk(illegal == (vld && !legal), {tag, " illegal flag R10"},
        {31'd0, illegal}, {31'd0, vld && !legal});
    @(negedge clk);
    instr_valid = 1'b0;
    if (vld && legal && d != 0) mdl[d] = v;
    q.push_back('{d, tag});
  endtask

  // monitor: pop expectations and compare through the debug port (R12)
  task automatic drain();
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      dbg_addr = e.r;
      #1;
      chk(dbg_data == mdl[e.r], {e.tag, " R12"}, dbg_data, mdl[e.r]);
    end
  endtask

  task automatic peek(input int r, input string tag);
    q.push_back('{5'(r), tag});
    drain();
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    chk(instr_ready == 1'b0, "R1 ready low in reset", {31'd0, instr_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(instr_ready == 1'b1, "R1 ready after reset", {31'd0, instr_ready}, 32'd1);
    begin
      int nz = 0;
      for (int i = 0; i < 32; i++) begin
        dbg_addr = 5'(i); #1;
        if (dbg_data != 0) nz++;
      end
      chk(nz == 0, "R1 registers cleared", 32'(nz), 32'd0);
    end

    drive(it_w(15, 0, 17, 16'h1234), 1, "R8 lui");            drain();
    drive(it_w(13, 17, 17, 16'h5678), 1, "R7 ori");           drain();
    chk(mdl[17] == 32'h12345678, "R7 R8 model", mdl[17], 32'h12345678);
    drive(it_w(15, 0, 18, 16'hFFFF), 1, "R8 lui negative");   drain();
    drive(it_w(13, 18, 18, 16'h0001), 1, "R7 ori low");       drain();
    drive(rt_w(17, 18, 9, 32), 1, "R2 add");                  drain();
    drive(rt_w(17, 18, 10, 34), 1, "R3 sub wrap");            drain();
    drive(rt_w(18, 17, 10, 34), 1, "R3 sub other way");       drain();
    drive(rt_w(18, 17, 11, 42), 1, "R4 slt neg<pos");         drain();
    drive(rt_w(17, 18, 12, 42), 1, "R4 slt pos<neg");         drain();
    drive(rt_w(17, 17, 12, 42), 1, "R4 slt equal");           drain();
    drive(it_w(8, 17, 13, 16'hFFFF), 1, "R5 addi minus one"); drain();
    peek(31, "R5 rd field ignored");
    drive(it_w(8, 18, 13, 16'h7FFF), 1, "R5 addi positive");  drain();
    drive(it_w(10, 17, 14, 16'h8000), 1, "R6 slti sext");     drain();
    drive(it_w(10, 18, 15, 16'h0005), 1, "R6 slti neg");      drain();
    drive(it_w(12, 18, 16, 16'h8001), 1, "R7 andi zext");     drain();
    drive(it_w(13, 0, 19, 16'h8000), 1, "R7 ori zext");       drain();
    peek(31, "R5 R7 r31 untouched");
    drive(it_w(8, 17, 0, 16'h0005), 1, "R9 write r0");        drain();
    drive(rt_w(0, 17, 20, 32), 1, "R9 r0 operand");           drain();
    drive(it_w(63, 0, 21, 16'hF800), 1, "R10 bad opcode");    drain();
    drive(it_w(9, 17, 21, 16'h0001), 1, "R10 opcode 9");      drain();
    drive(rt_w(17, 18, 22, 7), 1, "R10 bad funct");           drain();
    drive(rt_w(17, 18, 23, 32), 0, "R11 valid low");          drain();
    drive(it_w(15, 0, 24, 16'hBEEF), 0, "R11 lui idle");      drain();

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 32; i++) mdl[i] = 0;
    peek(9, "R1 reset again r9");
    peek(17, "R1 reset again r17");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule